// File: doc/BRIEF.md
# Idle-Exit Glitch Filter

This block cleans up an active-low sleep-request line coming from a processor before a power-state sequencer acts on it. A low level means the processor is asking for low-power idle, and that request is passed on as soon as it appears. A return to high means the processor wants to leave idle. That exit is believed only after the line has stayed high for a set number of millisecond ticks. A short high spike is never reported as an exit.

The raw line is asynchronous, so it first passes through a synchronizer chain. The output is a filtered level, `level_o`, equal to the synchronized line ANDed with an internal "validated" flag. A high that is still being checked therefore reads as low. Alongside the level comes `event_o`, a strobe that tells the sequencer when the filtered level has moved. A free-running millisecond tick from elsewhere in the chip paces the check window. The block holds no timer of real time of its own.

Top module: `idle_exit_filter`

## Requirements
- R1: A change of `line_raw_n` sampled at a clock edge reaches the filter after SYNC_STAGES clock edges, the sampling edge included. A low-to-high change of the synchronized line starts a pending check.
- R2: If the synchronized line is still high on the DELAY_TICKS-th `tick_ms` pulse sampled after the check started, the check succeeds. From that edge on, `level_o` reads 1 and `event_o` is 1 for that cycle.
- R3: A high-to-low change of the synchronized line with no check pending makes `level_o` read 0 and pulses `event_o` in the same cycle. Both follow the raw change by SYNC_STAGES edges.
- R4: While a check is pending, `level_o` reads 0.
- R5: The pending check ends at its DELAY_TICKS-th tick whatever the line level. If the line is low then, no event is issued. A later high-going change must again wait a full DELAY_TICKS ticks, and a later falling change is reported at once.
- R6: While and right after reset, `level_o` is 1, `event_o` is 0 and no check is pending.
- R7: `event_o` is 1 in exactly those cycles in which `level_o` differs from its value in the previous cycle. Each change gives a one-cycle pulse.
- R8: A new low-to-high change while a check is pending restarts the tick count from zero.
- R9: A high-to-low change while a check is pending issues no event, and `level_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_raw_n | input | 1 | Raw active-low sleep-request line, asynchronous |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| level_o | output | 1 | Filtered line level (1 = no sleep request) |
| event_o | output | 1 | One-cycle strobe on each change of `level_o` |

## Verification
The assertions take `tick_ms` to be a single-cycle pulse. They also expect the raw line to hold each level long enough to pass the synchronizer cleanly. No other constraint is placed on the raw line, so glitches of one cycle, re-rises during a check and falls during a check are all legal stimulus.

The bench issues ticks only through a task that produces one-cycle pulses. It changes the raw line on falling clock edges and waits past the synchronizer latency before it issues ticks. The sweep of high-pulse widths includes a zero-width glitch and widths on either side of DELAY_TICKS.

// File: rtl/idle_filt_pkg.sv
package idle_filt_pkg;

  // width of a counter able to hold 0 .. limit
  function automatic int cnt_bits(input int limit);
    int w;
    w = 1;
    while ((1 << w) <= limit) w++;
    return w;
  endfunction

  // the tick that closes the check window
  function automatic bit is_last_tick(input int count, input int delay);
    return (count == delay - 1);
  endfunction

endpackage

// File: rtl/idle_sync.sv
module idle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic nxt_o,   // value the filter sees from the next edge on
  output logic cur_o,   // synchronized level now
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign nxt_o  = chain_q[STAGES-2];
  assign cur_o  = chain_q[STAGES-1];
  assign rise_o = nxt_o & ~cur_o;
  assign fall_o = ~nxt_o & cur_o;

  // R1: a detected rise lands in the synchronized level one edge later
  p_rise_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> cur_o);

endmodule

// File: rtl/idle_timer.sv
module idle_timer
  import idle_filt_pkg::*;
#(
  parameter int DELAY_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic tick_i,
  output logic pending_o,
  output logic expire_o
);

  localparam int CW = cnt_bits(DELAY_TICKS);

  logic [CW-1:0] cnt_q;
  logic          pending_q;

  assign expire_o  = pending_q & tick_i & ~rise_i &
                     is_last_tick(int'(cnt_q), DELAY_TICKS);
  assign pending_o = pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (rise_i) begin
      pending_q <= 1'b1;
      cnt_q     <= '0;
    end else if (expire_o) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (pending_q && tick_i) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end

  // R1: a rise always opens a check
  p_rise_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> pending_q);
  // R5: every check closes at its expiry
  p_pending_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !pending_q);
  // R8: count never runs past the window
  p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < DELAY_TICKS);

endmodule

// File: rtl/idle_core.sv
module idle_core (
  input  logic clk,
  input  logic rst_n,
  input  logic nxt_i,
  input  logic fall_i,
  input  logic pending_i,
  input  logic expire_i,
  output logic done_o,
  output logic event_o
);

  logic done_q, event_q;
  logic pass_w, drop_w;

  assign pass_w = expire_i & nxt_i;       // check succeeded
  assign drop_w = fall_i & ~pending_i;    // immediate sleep entry

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b1;
      event_q <= 1'b0;
    end else if (pass_w) begin
      done_q  <= 1'b1;
      event_q <= 1'b1;
    end else if (drop_w) begin
      done_q  <= 1'b0;
      event_q <= 1'b1;
    end else begin
      event_q <= 1'b0;
    end
  end

  assign done_o  = done_q;
  assign event_o = event_q;

  // R3: an unguarded fall clears the validated flag
  p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !pending_i) |=> !done_q);
  // R9: a fall during a check raises no event
  p_fall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && pending_i && !expire_i) |=> !event_q);

endmodule

// File: rtl/idle_exit_filter.sv
module idle_exit_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw_n,
  input  logic tick_ms,
  output logic level_o,
  output logic event_o
);

  logic nxt_w, cur_w, rise_w, fall_w;
  logic pending_w, expire_w, done_w;

  idle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (line_raw_n),
    .nxt_o  (nxt_w),
    .cur_o  (cur_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  idle_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise_w),
    .tick_i    (tick_ms),
    .pending_o (pending_w),
    .expire_o  (expire_w)
  );

  idle_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_i     (nxt_w),
    .fall_i    (fall_w),
    .pending_i (pending_w),
    .expire_i  (expire_w),
    .done_o    (done_w),
    .event_o   (event_o)
  );

  assign level_o = cur_w & done_w;

  // R4: an unvalidated high never shows
  p_masked_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pending_w |-> !level_o);
  // R7: every event marks a change of the level
  p_event_is_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (level_o != $past(level_o)));
  // R7: every change of the level carries an event
  p_change_has_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> event_o);
  // R2: the level rises only through a successful check
  p_rise_validated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_o) |-> $past(expire_w));

endmodule

// File: tb/idle_exit_filter_tb_top.sv
module idle_exit_filter_tb_top;

  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_raw_n = 1'b1;
  logic tick_ms = 1'b0;
  logic level_o, event_o;

  int n_cmp = 0;
  int n_bad = 0;
  int ev_cnt = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  idle_exit_filter #(.SYNC_STAGES(2), .DELAY_TICKS(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_raw_n(line_raw_n),
    .tick_ms(tick_ms), .level_o(level_o), .event_o(event_o)
  );

  always @(posedge clk) if (rst_n && event_o) ev_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic set_line(input logic v);
    @(negedge clk) line_raw_n = v;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    // R6: reset state
    chk("R6 level in reset", level_o, 1);
    chk("R6 event in reset", event_o, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R6 level after reset", level_o, 1);
    chk("R6 event after reset", event_o, 0);

    // R1/R3: fall reported after two edges with an event
    set_line(1'b0);
    cyc(1);
    chk("R1 level before sync latency", level_o, 1);
    cyc(1);
    chk("R3 level after fall", level_o, 0);
    chk("R3 event on fall", event_o, 1);
    cyc(1);
    chk("R7 event one cycle", event_o, 0);

    // R2/R4: validated exit
    set_line(1'b1);
    cyc(3);
    chk("R4 masked while pending", level_o, 0);
    tick(); tick();
    chk("R4 masked after two ticks", level_o, 0);
    tick();
    chk("R2 level after last tick", level_o, 1);
    chk("R2 event on validation", event_o, 1);
    cyc(1);
    chk("R7 event drops", event_o, 0);
    base = ev_cnt;
    tick(); cyc(2);
    chk("R2 idle tick no event", ev_cnt - base, 0);

    // R3 again then R9/R8: fall and re-rise inside a check
    set_line(1'b0);
    cyc(3);
    set_line(1'b1);
    cyc(3);
    tick(); tick();
    base = ev_cnt;
    set_line(1'b0);
    cyc(3);
    chk("R9 fall in check no event", ev_cnt - base, 0);
    chk("R9 level stays low", level_o, 0);
    set_line(1'b1);
    cyc(3);
    tick(); tick();
    chk("R8 restart keeps masked", level_o, 0);
    chk("R8 restart no event", ev_cnt - base, 0);
    tick();
    chk("R8 level after full window", level_o, 1);

    // R5: failed check, then a fresh rise needs the full window
    set_line(1'b0);
    cyc(3);
    set_line(1'b1);
    cyc(3);
    tick();
    set_line(1'b0);
    cyc(3);
    base = ev_cnt;
    tick(); tick(); cyc(2);
    chk("R5 failed check no event", ev_cnt - base, 0);
    set_line(1'b1);
    cyc(3);
    tick(); tick();
    chk("R5 new check needs full window", level_o, 0);
    tick();
    chk("R5 new check passes", level_o, 1);
    set_line(1'b0);
    cyc(2);
    chk("R5 fall after check reported", event_o, 1);
    cyc(2);

    // sweep of high-pulse widths in ticks (0 = one-cycle glitch)
    for (int w = 0; w <= 5; w++) begin
      base = ev_cnt;
      if (w == 0) begin
        set_line(1'b1);
        set_line(1'b0);
        cyc(3);
      end else begin
        set_line(1'b1);
        cyc(3);
        for (int t = 0; t < w; t++) tick();
        chk($sformatf("R2 width %0d level high", w), level_o, (w >= DLY) ? 1 : 0);
        set_line(1'b0);
        cyc(3);
      end
      chk($sformatf("R3 width %0d level low", w), level_o, 0);
      for (int t = 0; t < DLY; t++) tick();
      cyc(2);
      chk($sformatf("R7 width %0d event count", w), ev_cnt - base, (w >= DLY) ? 2 : 0);
    end

    done_run = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule